// File: doc/BRIEF.md
# USB OUT endpoint buffer controller

This block handles the receive side of a single USB OUT endpoint. A serial interface engine delivers each packet as a start strobe, which carries the DATA0/DATA1 toggle of the packet, then a stream of bytes on a valid/ready interface, then an end strobe with CRC-error and bit-stuff-error flags. The block stores accepted packets in one buffer slot, or in two slots when double buffering is on. It chooses the handshake the engine sends back (ACK, NAK or STALL) and keeps the expected data toggle.

A CPU unloads packets through an 8-bit control/status register and a byte read port. Packet-ready is set, and a one-cycle interrupt is raised, whenever a stored packet becomes the head of the buffer. Clearing packet-ready releases the head slot. A one-shot flush discards the head packet without reading it. Isochronous mode sends no handshakes, ignores stall and toggle, keeps errored packets with a data-error flag, and records a lost packet in a sticky overrun flag.

Receive back-pressure: `rx_ready` is high from the cycle after `rx_start` until the packet's end, and low in the cycle that `rx_end` is asserted. A byte transfers when `rx_valid` and `rx_ready` are both high. The block never stalls a packet. Bytes beyond the slot depth are taken and dropped.

Top module: `usb_out_ep`

## Requirements
- R1: After reset the status register reads 0x00, `irq` and `hs_valid` are low, and the expected toggle is DATA0.
- R2: Status register bit positions are: 0 packet-ready, 1 full, 2 overrun, 3 data-error, 4 flush, 5 send-stall, 6 stall-sent, 7 clear-toggle. Bit 7 always reads 0, and writing 1 to it sets the expected toggle to DATA0 (`rx_toggle`=0).
- R3: In bulk/interrupt mode, an error-free packet whose toggle matches the expected toggle is stored. The expected toggle flips. `hs_valid` pulses with `hs_code`=0 (ACK) one cycle after `rx_end`. Packet-ready and a one-cycle `irq` follow one cycle later.
- R4: In bulk/interrupt mode, a good packet with the wrong toggle is answered with ACK but is not stored, and the expected toggle does not change.
- R5: Full reads 1 when one packet is held with `dbuf_en`=0, or two packets with `dbuf_en`=1. In bulk/interrupt mode, a packet that starts while the buffer is full is answered with `hs_code`=1 (NAK) and is not stored.
- R6: In bulk/interrupt mode, a packet with a CRC or bit-stuff error gets no handshake and is not stored.
- R7: While send-stall is 1 in bulk/interrupt mode, each error-free packet is answered with `hs_code`=2 (STALL) and sets stall-sent. Stall-sent stays 1 until written 0. In isochronous mode, send-stall has no effect.
- R8: A register write with bit 0 = 0 and bit 4 = 0 while packet-ready is 1 releases the head packet and clears packet-ready. If a second packet is queued, packet-ready and `irq` assert again one cycle later.
- R9: Writing bit 4 = 1 sets the flush bit for one cycle. Then the head packet is discarded, packet-ready clears, and the read pointer returns to byte 0. A flush write ignores bit 0. Each queued packet needs its own flush.
- R10: In isochronous mode there is no handshake. A packet with a CRC or stuff error is still stored, and data-error reads 1 while it is the ready head packet. Data-error reads 0 after packet-ready is cleared.
- R11: In isochronous mode, a packet that starts while the buffer is full is lost and sets overrun. Overrun stays 1 until written 0.
- R12: `rd_data` shows the head packet's byte at the read pointer, and each `rd_en` cycle advances the pointer. Reads at or past the packet length give 0. `rd_len` gives the stored length, which is capped at the 64-byte slot depth, or 0 when the buffer is empty.
- R13: `rx_ready` is 1 only between `rx_start` and `rx_end`, and is 0 in the cycle `rx_end` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iso_mode | input | 1 | 1 selects isochronous behaviour |
| dbuf_en | input | 1 | 1 allows two buffered packets |
| rx_start | input | 1 | Packet start strobe |
| rx_toggle | input | 1 | Toggle of the packet, sampled with rx_start |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte ready |
| rx_data | input | 8 | Receive byte |
| rx_end | input | 1 | Packet end strobe |
| rx_crc_err | input | 1 | CRC error, sampled with rx_end |
| rx_stuff_err | input | 1 | Bit-stuff error, sampled with rx_end |
| hs_valid | output | 1 | Handshake pulse |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register read value |
| rd_en | input | 1 | Advance the read pointer |
| rd_data | output | 8 | Byte at the read pointer |
| rd_len | output | 7 | Length of the head packet |
| irq | output | 1 | Packet-ready interrupt pulse |

## Verification
The handshake decision for a packet is registered at the `rx_end` edge, so `hs_valid`/`hs_code` appear one cycle after the end strobe. The stored count, and with it the full bit, updates at that same edge. Packet-ready and `irq` come one cycle after that. A register write takes effect at the edge that samples it, except flush, which discards one cycle later. The bench drives inputs on the falling edge and compares every output against a queue-based model a quarter period before the next rising edge, so each comparison sees the state those latencies produce. Directed checks are placed at the exact cycle offsets given above.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_code_e;

  localparam int CSR_CLRTOG = 7;
  localparam int CSR_STSENT = 6;
  localparam int CSR_SNDSTL = 5;
  localparam int CSR_FLUSH  = 4;
  localparam int CSR_DERR   = 3;
  localparam int CSR_OVR    = 2;
  localparam int CSR_FULL   = 1;
  localparam int CSR_RDY    = 0;
endpackage

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx
  import usb_out_ep_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iso_mode,
  input  logic          rx_start,
  input  logic          rx_toggle,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_end,
  input  logic          rx_crc_err,
  input  logic          rx_stuff_err,
  input  logic          full,
  input  logic          send_stall,
  input  logic          exp_toggle,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit,
  output logic          commit_err,
  output logic [PW-1:0] commit_len,
  output logic          stall_evt,
  output logic          ovr_evt,
  output logic          tog_flip,
  output logic          hs_valid,
  output logic [1:0]    hs_code
);
  logic          in_pkt, accept, tog_seen;
  logic [PW-1:0] wr_ptr;
  logic          beat, end_evt, pkt_err, room;
  logic          hs_fire;
  hs_code_e      hs_sel;

  assign rx_ready   = in_pkt & ~rx_end;
  assign beat       = rx_valid & rx_ready;
  assign room       = wr_ptr < PW'(DEPTH);
  assign wr_en      = beat & accept & room;
  assign wr_addr    = wr_ptr[AW-1:0];
  assign wr_data    = rx_data;
  assign end_evt    = rx_end & in_pkt;
  assign pkt_err    = rx_crc_err | rx_stuff_err;
  assign commit_len = wr_ptr;
  assign commit_err = pkt_err & iso_mode;

  always_comb begin
    commit    = 1'b0;
    ovr_evt   = 1'b0;
    stall_evt = 1'b0;
    tog_flip  = 1'b0;
    hs_fire   = 1'b0;
    hs_sel    = HS_ACK;
    if (end_evt) begin
      if (iso_mode) begin
        if (accept) commit = 1'b1;
        else        ovr_evt = 1'b1;
      end else if (!pkt_err) begin
        hs_fire = 1'b1;
        if (send_stall) begin
          hs_sel    = HS_STALL;
          stall_evt = 1'b1;
        end else if (!accept) begin
          hs_sel = HS_NAK;
        end else if (tog_seen == exp_toggle) begin
          commit   = 1'b1;
          tog_flip = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      accept   <= 1'b0;
      tog_seen <= 1'b0;
      wr_ptr   <= '0;
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
    end else begin
      hs_valid <= hs_fire;
      hs_code  <= hs_sel;
      if (rx_start) begin
        in_pkt   <= 1'b1;
        accept   <= ~full;
        tog_seen <= rx_toggle;
        wr_ptr   <= '0;
      end else begin
        if (end_evt) in_pkt <= 1'b0;
        if (beat && room) wr_ptr <= wr_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_out_ep_store.sv
module usb_out_ep_store #(
  parameter int DEPTH = 64,
  parameter int NSLOT = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1),
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic          commit_err,
  input  logic [PW-1:0] commit_len,
  input  logic [SW-1:0] rd_slot,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    slot_byte,
  output logic [PW-1:0] slot_len,
  output logic          slot_err
);
  logic [7:0]    byte_s [NSLOT];
  logic [PW-1:0] len_s  [NSLOT];
  logic          err_s  [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] len_q;
    logic          err_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_slot == SW'(g)) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q <= '0;
        err_q <= 1'b0;
      end else if (commit && wr_slot == SW'(g)) begin
        len_q <= commit_len;
        err_q <= commit_err;
      end
    end

    assign byte_s[g] = mem[rd_addr];
    assign len_s[g]  = len_q;
    assign err_s[g]  = err_q;
  end

  assign slot_byte = byte_s[rd_slot];
  assign slot_len  = len_s[rd_slot];
  assign slot_err  = err_s[rd_slot];
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_out_ep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NSLOT = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1),
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iso_mode,
  input  logic          dbuf_en,
  input  logic          csr_wr,
  input  logic [7:0]    csr_wdata,
  output logic [7:0]    csr_rdata,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [PW-1:0] rd_len,
  output logic          irq,
  input  logic          commit,
  input  logic          stall_evt,
  input  logic          ovr_evt,
  input  logic          tog_flip,
  input  logic [7:0]    slot_byte,
  input  logic [PW-1:0] slot_len,
  input  logic          slot_err,
  output logic          full,
  output logic          exp_toggle,
  output logic          send_stall,
  output logic [SW-1:0] wr_slot,
  output logic [SW-1:0] rd_slot,
  output logic [AW-1:0] rd_addr
);
  logic [CW-1:0] cnt, cap;
  logic [PW-1:0] rd_ptr;
  logic          opr, flush_pend, stall_sent, overrun;
  logic          have, opr_clr, pop, data_err;
  logic          unused_wbits;

  function automatic logic [SW-1:0] slot_next(input logic [SW-1:0] s);
    return (s == SW'(NSLOT - 1)) ? '0 : s + 1'b1;
  endfunction

  assign cap      = dbuf_en ? CW'(NSLOT) : CW'(1);
  assign full     = cnt >= cap;
  assign have     = cnt != '0;
  assign opr_clr  = csr_wr & ~csr_wdata[CSR_FLUSH] & ~csr_wdata[CSR_RDY] & opr;
  assign pop      = (flush_pend & have) | opr_clr;
  assign data_err = opr & iso_mode & slot_err;
  assign rd_addr  = rd_ptr[AW-1:0];
  assign rd_len   = have ? slot_len : '0;
  assign rd_data  = (have && rd_ptr < slot_len) ? slot_byte : 8'h00;
  assign unused_wbits = ^{csr_wdata[CSR_DERR], csr_wdata[CSR_FULL]};

  always_comb begin
    csr_rdata             = 8'h00;
    csr_rdata[CSR_STSENT] = stall_sent;
    csr_rdata[CSR_SNDSTL] = send_stall;
    csr_rdata[CSR_FLUSH]  = flush_pend;
    csr_rdata[CSR_DERR]   = data_err;
    csr_rdata[CSR_OVR]    = overrun;
    csr_rdata[CSR_FULL]   = full;
    csr_rdata[CSR_RDY]    = opr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      wr_slot    <= '0;
      rd_slot    <= '0;
      rd_ptr     <= '0;
      opr        <= 1'b0;
      irq        <= 1'b0;
      flush_pend <= 1'b0;
      stall_sent <= 1'b0;
      overrun    <= 1'b0;
      send_stall <= 1'b0;
      exp_toggle <= 1'b0;
    end else begin
      irq        <= 1'b0;
      flush_pend <= csr_wr & csr_wdata[CSR_FLUSH];

      if (pop) begin
        opr <= 1'b0;
      end else if (!opr && have) begin
        opr <= 1'b1;
        irq <= 1'b1;
      end

      if (commit && !pop)      cnt <= cnt + 1'b1;
      else if (!commit && pop) cnt <= cnt - 1'b1;
      if (commit) wr_slot <= slot_next(wr_slot);
      if (pop)    rd_slot <= slot_next(rd_slot);

      if (pop)                               rd_ptr <= '0;
      else if (rd_en && rd_ptr < PW'(DEPTH)) rd_ptr <= rd_ptr + 1'b1;

      if (csr_wr && csr_wdata[CSR_CLRTOG]) exp_toggle <= 1'b0;
      else if (tog_flip)                   exp_toggle <= ~exp_toggle;

      if (stall_evt)                             stall_sent <= 1'b1;
      else if (csr_wr && !csr_wdata[CSR_STSENT]) stall_sent <= 1'b0;

      if (ovr_evt)                            overrun <= 1'b1;
      else if (csr_wr && !csr_wdata[CSR_OVR]) overrun <= 1'b0;

      if (csr_wr) send_stall <= csr_wdata[CSR_SNDSTL];
    end
  end
endmodule

// File: rtl/usb_out_ep.sv
module usb_out_ep #(
  parameter int DEPTH = 64,
  parameter int NSLOT = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1),
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iso_mode,
  input  logic          dbuf_en,
  input  logic          rx_start,
  input  logic          rx_toggle,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_end,
  input  logic          rx_crc_err,
  input  logic          rx_stuff_err,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  input  logic          csr_wr,
  input  logic [7:0]    csr_wdata,
  output logic [7:0]    csr_rdata,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [PW-1:0] rd_len,
  output logic          irq
);
  logic          full, send_stall, exp_toggle;
  logic          wr_en, commit, commit_err, stall_evt, ovr_evt, tog_flip;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, slot_byte;
  logic [PW-1:0] commit_len, slot_len;
  logic          slot_err;
  logic [SW-1:0] wr_slot, rd_slot;

  usb_out_ep_rx #(.DEPTH(DEPTH)) u_rx (
    .clk, .rst_n, .iso_mode,
    .rx_start, .rx_toggle, .rx_valid, .rx_ready, .rx_data,
    .rx_end, .rx_crc_err, .rx_stuff_err,
    .full, .send_stall, .exp_toggle,
    .wr_en, .wr_addr, .wr_data,
    .commit, .commit_err, .commit_len,
    .stall_evt, .ovr_evt, .tog_flip,
    .hs_valid, .hs_code
  );

  usb_out_ep_store #(.DEPTH(DEPTH), .NSLOT(NSLOT)) u_store (
    .clk, .rst_n,
    .wr_en, .wr_slot, .wr_addr, .wr_data,
    .commit, .commit_err, .commit_len,
    .rd_slot, .rd_addr,
    .slot_byte, .slot_len, .slot_err
  );

  usb_out_ep_ctrl #(.DEPTH(DEPTH), .NSLOT(NSLOT)) u_ctrl (
    .clk, .rst_n, .iso_mode, .dbuf_en,
    .csr_wr, .csr_wdata, .csr_rdata,
    .rd_en, .rd_data, .rd_len, .irq,
    .commit, .stall_evt, .ovr_evt, .tog_flip,
    .slot_byte, .slot_len, .slot_err,
    .full, .exp_toggle, .send_stall,
    .wr_slot, .rd_slot, .rd_addr
  );
endmodule

// File: rtl/usb_out_ep_chk.sv
module usb_out_ep_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iso_mode,
  input logic       rx_end,
  input logic       rx_ready,
  input logic       hs_valid,
  input logic       csr_wr,
  input logic [7:0] csr_rdata,
  input logic       irq
);
  // R13
  ready_low_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> !rx_ready);

  // R3
  hs_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(rx_end));

  // R10
  iso_no_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && iso_mode) |=> !hs_valid);

  // R7
  stall_sent_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[6] && !csr_wr) |=> csr_rdata[6]);

  // R8
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R3
  irq_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> csr_rdata[0]);
endmodule

bind usb_out_ep usb_out_ep_chk i_chk (.*);

// File: tb/test_usb_out_ep.sv
module test_usb_out_ep;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iso_mode = 1'b0, dbuf_en = 1'b0;
  logic       rx_start = 1'b0, rx_toggle = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
  logic       rx_crc_err = 1'b0, rx_stuff_err = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       csr_wr = 1'b0, rd_en = 1'b0;
  logic [7:0] csr_wdata = 8'h00;
  logic       rx_ready, hs_valid, irq;
  logic [1:0] hs_code;
  logic [7:0] csr_rdata, rd_data;
  logic [6:0] rd_len;

  always #10 clk = ~clk;

  usb_out_ep i_usb_out_ep (
    .clk, .rst_n, .iso_mode, .dbuf_en,
    .rx_start, .rx_toggle, .rx_valid, .rx_ready, .rx_data,
    .rx_end, .rx_crc_err, .rx_stuff_err,
    .hs_valid, .hs_code,
    .csr_wr, .csr_wdata, .csr_rdata,
    .rd_en, .rd_data, .rd_len, .irq
  );

  int  n_checks = 0, n_errors = 0;
  bit  live = 0, done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef logic [7:0] pkt_t [64];
  pkt_t q_dat[$];
  int   q_len[$];
  bit   q_err[$];
  pkt_t cur;
  int   cur_n, m_ptr;
  bit   m_in, m_acc, m_tog, m_exp, m_opr, m_irq, m_hsv;
  bit   m_sst, m_ssd, m_ovr, m_flush;
  logic [1:0] m_hsc;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_dat.delete(); q_len.delete(); q_err.delete();
      cur_n = 0; m_ptr = 0;
      {m_in, m_acc, m_tog, m_exp, m_opr, m_irq, m_hsv} = '0;
      {m_sst, m_ssd, m_ovr, m_flush} = '0;
      m_hsc = 2'd0;
    end else begin
      int  sz;
      bit  full_o, take, flip, sset, oset, pop;
      sz = q_dat.size();
      full_o = sz >= (dbuf_en ? 2 : 1);
      take = 0; flip = 0; sset = 0; oset = 0;
      m_hsv = 0; m_hsc = 2'd0; m_irq = 0;
      if (rx_end && m_in) begin
        if (iso_mode) begin
          if (m_acc) take = 1; else oset = 1;
        end else if (!(rx_crc_err || rx_stuff_err)) begin
          m_hsv = 1;
          if (m_ssd) begin m_hsc = 2'd2; sset = 1; end
          else if (!m_acc) m_hsc = 2'd1;
          else if (m_tog == m_exp) begin take = 1; flip = 1; end
        end
      end
      pop = (m_flush && sz > 0) ||
            (csr_wr && !csr_wdata[4] && !csr_wdata[0] && m_opr);
      if (pop) m_opr = 0;
      else if (!m_opr && sz > 0) begin m_opr = 1; m_irq = 1; end
      if (pop) m_ptr = 0;
      else if (rd_en && m_ptr < 64) m_ptr++;
      if (pop) begin
        void'(q_dat.pop_front()); void'(q_len.pop_front()); void'(q_err.pop_front());
      end
      if (take) begin
        q_dat.push_back(cur); q_len.push_back(cur_n);
        q_err.push_back(iso_mode && (rx_crc_err || rx_stuff_err));
      end
      if (csr_wr && csr_wdata[7]) m_exp = 0; else if (flip) m_exp = ~m_exp;
      if (sset) m_sst = 1; else if (csr_wr && !csr_wdata[6]) m_sst = 0;
      if (oset) m_ovr = 1; else if (csr_wr && !csr_wdata[2]) m_ovr = 0;
      if (csr_wr) m_ssd = csr_wdata[5];
      m_flush = csr_wr && csr_wdata[4];
      if (rx_start) begin
        m_in = 1; m_acc = !full_o; m_tog = rx_toggle; cur_n = 0;
      end else if (rx_end && m_in) begin
        m_in = 0;
      end else if (rx_valid && m_in && cur_n < 64) begin
        cur[cur_n] = rx_data; cur_n++;
      end
    end
  end

  // compare every cycle, a quarter period before the rising edge
  always begin
    @(negedge clk); #5;
    if (live && rst_n) begin
      int   sz;
      logic [7:0] e_csr, e_rd;
      int   e_len;
      sz = q_dat.size();
      e_csr = {1'b0, m_sst, m_ssd, m_flush,
               (m_opr && iso_mode && sz > 0 && q_err[0]), m_ovr,
               (sz >= (dbuf_en ? 2 : 1)), m_opr};
      e_rd  = (sz > 0 && m_ptr < q_len[0]) ? q_dat[0][m_ptr] : 8'h00;
      e_len = (sz > 0) ? q_len[0] : 0;
      chk("R2 model csr_rdata", csr_rdata, e_csr);
      chk("R8 model irq", irq, m_irq);
      chk("R3 model hs_valid", hs_valid, m_hsv);
      chk("R3 model hs_code", hs_code, m_hsc);
      chk("R12 model rd_data", rd_data, e_rd);
      chk("R12 model rd_len", rd_len, e_len);
      chk("R13 model rx_ready", rx_ready, m_in && !rx_end);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic send_pkt(input bit tog, input int n, input int seed,
                          input bit crc, input bit stf);
    @(negedge clk); rx_start = 1; rx_toggle = tog;
    @(negedge clk); rx_start = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = 8'(seed + i);
      @(negedge clk);
    end
    rx_valid = 0; rx_end = 1; rx_crc_err = crc; rx_stuff_err = stf;
    @(negedge clk); rx_end = 0; rx_crc_err = 0; rx_stuff_err = 0;
    #5;
  endtask

  task automatic csr_write(input logic [7:0] v);
    @(negedge clk); csr_wr = 1; csr_wdata = v;
    @(negedge clk); csr_wr = 0;
    #5;
  endtask

  task automatic read_bytes(input int k);
    @(negedge clk); rd_en = 1;
    repeat (k) @(negedge clk);
    rd_en = 0;
    #5;
  endtask

  task automatic step();
    @(negedge clk); #5;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    #5;
    // R1 reset state
    chk("R1 csr after reset", csr_rdata, 8'h00);
    chk("R1 irq after reset", irq, 0);
    chk("R1 hs_valid after reset", hs_valid, 0);

    // R3 good packet with DATA0 in single-buffer bulk mode
    send_pkt(0, 5, 8'h10, 0, 0);
    chk("R3 ACK valid", hs_valid, 1);
    chk("R3 ACK code", hs_code, 0);
    step();
    chk("R3 ready+full csr", csr_rdata, 8'h03);
    chk("R3 irq pulse", irq, 1);
    chk("R12 first byte", rd_data, 8'h10);
    read_bytes(7);
    chk("R12 past length reads 0", rd_data, 8'h00);
    chk("R12 length", rd_len, 5);

    // R5 NAK when full
    send_pkt(1, 3, 8'h20, 0, 0);
    chk("R5 NAK valid", hs_valid, 1);
    chk("R5 NAK code", hs_code, 1);
    csr_write(8'h00);
    chk("R8 clear ready", csr_rdata, 8'h00);

    // R4 toggle mismatch: ACK, dropped
    send_pkt(0, 4, 8'h30, 0, 0);
    chk("R4 mismatch ACK", hs_code, 0);
    step(); step();
    chk("R4 mismatch not stored", csr_rdata[0], 0);
    csr_write(8'h80);
    chk("R2 clear-toggle reads 0", csr_rdata[7], 0);
    send_pkt(0, 3, 8'h38, 0, 0);
    step();
    chk("R4 accepted after toggle clear", csr_rdata[0], 1);
    csr_write(8'h00);

    // R6 errored packets in bulk mode
    send_pkt(1, 3, 8'h50, 1, 0);
    chk("R6 CRC error no handshake", hs_valid, 0);
    send_pkt(1, 3, 8'h50, 0, 1);
    chk("R6 stuff error no handshake", hs_valid, 0);
    step();
    chk("R6 not stored", csr_rdata[0], 0);

    // R7 stall
    csr_write(8'h20);
    send_pkt(1, 2, 8'h58, 0, 0);
    chk("R7 STALL code", hs_code, 2);
    step(); step(); step();
    chk("R7 stall-sent sticky", csr_rdata, 8'h60);
    csr_write(8'h00);
    chk("R7 stall cleared", csr_rdata, 8'h00);

    // R5/R8/R9 double buffering
    @(negedge clk); dbuf_en = 1;
    send_pkt(1, 4, 8'h40, 0, 0);
    step();
    chk("R5 one of two not full", csr_rdata, 8'h01);
    send_pkt(0, 6, 8'h60, 0, 0);
    chk("R5 two packets full", csr_rdata, 8'h03);
    csr_write(8'h00);
    chk("R8 cleared with one queued", csr_rdata, 8'h00);
    step();
    chk("R8 ready reasserts", csr_rdata, 8'h01);
    chk("R8 irq again", irq, 1);
    chk("R8 second length", rd_len, 6);
    read_bytes(2);
    chk("R12 pointer advanced", rd_data, 8'h62);
    send_pkt(1, 2, 8'h80, 0, 0);
    chk("R5 full again", csr_rdata, 8'h03);
    csr_write(8'h10);
    chk("R9 flush bit visible", csr_rdata, 8'h13);
    step();
    chk("R9 head discarded", csr_rdata, 8'h00);
    step();
    chk("R9 pointer reset on next packet", rd_data, 8'h80);
    csr_write(8'h10);
    chk("R9 second flush visible", csr_rdata, 8'h11);
    step();
    chk("R9 empty after second flush", rd_len, 0);

    // R10/R11 isochronous
    @(negedge clk); dbuf_en = 0; iso_mode = 1;
    send_pkt(0, 3, 8'hA0, 1, 0);
    chk("R10 no handshake", hs_valid, 0);
    step();
    chk("R10 data error with ready", csr_rdata, 8'h0B);
    send_pkt(1, 3, 8'hB0, 0, 0);
    chk("R11 overrun set", csr_rdata, 8'h0F);
    csr_write(8'h04);
    chk("R10 data error cleared", csr_rdata, 8'h04);
    csr_write(8'h00);
    chk("R11 overrun cleared", csr_rdata, 8'h00);
    csr_write(8'h20);
    send_pkt(1, 2, 8'hC0, 0, 0);
    chk("R7 iso ignores stall", hs_valid, 0);
    step();
    chk("R7 iso stored despite stall", csr_rdata, 8'h23);
    csr_write(8'h20);
    csr_write(8'h00);

    // R12/R13 long packet in bulk mode
    @(negedge clk); iso_mode = 0;
    csr_write(8'h80);
    send_pkt(0, 70, 8'h01, 0, 0);
    step();
    chk("R12 length capped", rd_len, 64);
    chk("R13 ready low when idle", rx_ready, 0);
    csr_write(8'h00);
    step();

    done = 1;
    finish_run();
  end
endmodule